// File: doc/BRIEF.md
# Commutation Preload Shadow Register

This block keeps the per-channel output control of a multi-channel timer: a channel-enable bit, a complementary-enable bit and an output-mode field. Each channel has two copies of that control word. The buffered copy always takes the value software writes. The active copy drives the output stage. On channels that have a complementary output, a preload switch selects when the active copy changes. With the switch off, a write reaches the active copy at once. With it on, the active copy changes only on a commutation event, and every complementary channel changes in the same clock edge.

A commutation event comes from a one-cycle software strobe. A second selection input can also let a rising edge on the trigger input cause the event. The rising edge is found by comparing the trigger input with a registered copy of it. Channels without a complementary output ignore the preload switch and always take writes immediately. A one-cycle flag marks each transfer from the buffered copies to the active copies.

Writes arrive on a valid/ready channel. The block takes a word on every cycle in which `wr_valid` is high. `wr_ready` is tied high, so no back-pressure is ever applied, and the writer never needs to hold a word.

Top module: `comm_shadow_ctl`

## Requirements
- R1: After reset, every active and buffered control word is zero and `com_pulse` is low.
- R2: With `preload_on` low, a write to a complementary channel appears on its active outputs one cycle after the write is accepted.
- R3: With `preload_on` high, a write to a complementary channel leaves its active outputs unchanged until a commutation event.
- R4: With `upd_sel` low, only `com_sw` causes a commutation event, and a rising edge on `trig_in` causes no transfer.
- R5: With `upd_sel` high, a low-to-high change of `trig_in` between two consecutive clock edges causes a commutation event. Holding `trig_in` high causes no further event.
- R6: With `upd_sel` high, `com_sw` still causes a commutation event.
- R7: Channels numbered `NUM_COMP` and above take writes one cycle later whatever `preload_on` is, and their complementary-enable output always reads 0.
- R8: On a commutation event, all complementary channels load their buffered words at the same edge. If a write lands in that same cycle, the word that was buffered before it is the one transferred, and the new word stays buffered for the next event.
- R9: `com_pulse` is high for exactly the cycle in which the transferred values first appear, and it never rises while `preload_on` is low.
- R10: `wr_ready` is always high, so every cycle with `wr_valid` high is accepted.
- R11: A write whose `wr_chan` is `NUM_CH` or more changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write word valid |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_chan | input | CH_W | Channel index of the write |
| wr_en | input | 1 | Channel enable bit to write |
| wr_cen | input | 1 | Complementary enable bit to write |
| wr_mode | input | MODE_W | Output mode field to write |
| preload_on | input | 1 | 1: complementary channels are buffered until commutation |
| upd_sel | input | 1 | 0: software strobe only; 1: strobe or trigger rising edge |
| com_sw | input | 1 | Software commutation strobe, one cycle |
| trig_in | input | 1 | Trigger input |
| act_en | output | NUM_CH | Active channel enable bits |
| act_cen | output | NUM_CH | Active complementary enable bits |
| act_mode | output | NUM_CH*MODE_W | Active mode fields, channel i at [i*MODE_W +: MODE_W] |
| com_pulse | output | 1 | One-cycle flag marking a transfer |

## Verification
The bench goes after the same-cycle collision of a write and a commutation event. A design that forwards the new word would show it one event too early. It also holds the trigger high across many cycles, which shows up a level detector as repeated transfers, and it drives a trigger edge with `upd_sel` low to catch a source selection that ignores the select. Writes to the highest out-of-range indices, and complementary-enable writes to plain channels, expose decode or masking faults. A long pseudo-random sweep compares every output against an arithmetic model on every cycle, so a transfer that misses one channel or a flag that arrives a cycle off is caught.

// File: rtl/comm_shadow_pkg.sv
package comm_shadow_pkg;
  typedef enum logic {
    SRC_SW_ONLY    = 1'b0,
    SRC_SW_OR_TRIG = 1'b1
  } com_src_e;
endpackage

// File: rtl/cs_trig_edge.sv
module cs_trig_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic rise_o
);
  logic trig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_i;
  end

  assign rise_o = trig_i & ~trig_q;

  // R5
  rise_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> trig_q);
endmodule

// File: rtl/cs_com_event.sv
module cs_com_event
  import comm_shadow_pkg::*;
(
  input  logic     sw_i,
  input  logic     rise_i,
  input  com_src_e sel_i,
  input  logic     preload_i,
  output logic     xfer_o
);
  logic evt;

  always_comb begin
    unique case (sel_i)
      SRC_SW_ONLY:    evt = sw_i;
      SRC_SW_OR_TRIG: evt = sw_i | rise_i;
      default:        evt = sw_i;
    endcase
    xfer_o = evt & preload_i;
  end
endmodule

// File: rtl/cs_chan_slot.sv
module cs_chan_slot #(
  parameter int MODE_W   = 3,
  parameter bit HAS_COMP = 1'b1,
  localparam int W = MODE_W + 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic [W-1:0] wr_word,
  input  logic         preload_i,
  input  logic         xfer_i,
  output logic [W-1:0] act_o
);
  logic [W-1:0] word_m;
  logic [W-1:0] pre_q;
  logic [W-1:0] act_q;

  generate
    if (HAS_COMP) begin : g_mask_none
      assign word_m = wr_word;
    end else begin : g_mask_cen
      assign word_m = {wr_word[W-1], 1'b0, wr_word[MODE_W-1:0]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)      pre_q <= '0;
    else if (wr_hit) pre_q <= word_m;
  end

  generate
    if (HAS_COMP) begin : g_comp
      always_ff @(posedge clk) begin
        if (!rst_n)                     act_q <= '0;
        else if (xfer_i)                act_q <= pre_q;
        else if (!preload_i && wr_hit)  act_q <= word_m;
      end

      // R3
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_i && !xfer_i) |=> $stable(act_q));
      // R8
      xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_i |=> (act_q == $past(pre_q)));
      // R2
      direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!preload_i && wr_hit) |=> (act_q == $past(wr_word)));
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)      act_q <= '0;
        else if (wr_hit) act_q <= word_m;
      end

      // R7
      plain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(act_q));
      // R7
      plain_cen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (act_q[MODE_W] == 1'b0 && act_q[W-1] == $past(wr_word[W-1])));
    end
  endgenerate

  assign act_o = act_q;
endmodule

// File: rtl/comm_shadow_ctl.sv
module comm_shadow_ctl
  import comm_shadow_pkg::*;
#(
  parameter int NUM_CH   = 6,
  parameter int NUM_COMP = 3,
  parameter int MODE_W   = 3,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH + 1) : 1,
  localparam int W       = MODE_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic [CH_W-1:0]          wr_chan,
  input  logic                     wr_en,
  input  logic                     wr_cen,
  input  logic [MODE_W-1:0]        wr_mode,
  input  logic                     preload_on,
  input  logic                     upd_sel,
  input  logic                     com_sw,
  input  logic                     trig_in,
  output logic [NUM_CH-1:0]        act_en,
  output logic [NUM_CH-1:0]        act_cen,
  output logic [NUM_CH*MODE_W-1:0] act_mode,
  output logic                     com_pulse
);
  logic         rise;
  logic         xfer;
  logic [W-1:0] wr_word;
  com_src_e     src;

  assign wr_ready = 1'b1;
  assign wr_word  = {wr_en, wr_cen, wr_mode};
  assign src      = upd_sel ? SRC_SW_OR_TRIG : SRC_SW_ONLY;

  cs_trig_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (trig_in),
    .rise_o (rise)
  );

  cs_com_event u_evt (
    .sw_i      (com_sw),
    .rise_i    (rise),
    .sel_i     (src),
    .preload_i (preload_on),
    .xfer_o    (xfer)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
      logic         hit;
      logic [W-1:0] act;
      assign hit = wr_valid && (wr_chan == CH_W'(gi));
      cs_chan_slot #(
        .MODE_W   (MODE_W),
        .HAS_COMP (gi < NUM_COMP)
      ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (hit),
        .wr_word   (wr_word),
        .preload_i (preload_on),
        .xfer_i    (xfer),
        .act_o     (act)
      );
      assign act_en[gi]                   = act[W-1];
      assign act_cen[gi]                  = act[MODE_W];
      assign act_mode[gi*MODE_W +: MODE_W] = act[MODE_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) com_pulse <= 1'b0;
    else        com_pulse <= xfer;
  end

  // R9
  no_pulse_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !preload_on |=> !com_pulse);
  // R4
  sw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_sel && !com_sw) |=> !com_pulse);
  // R10
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready);
endmodule

// File: tb/comm_shadow_ctl_tb_top.sv
module comm_shadow_ctl_tb_top;
  localparam int NCH  = 6;
  localparam int NCMP = 3;
  localparam int MW   = 3;
  localparam int CW   = 3;
  localparam int W    = MW + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [CW-1:0] wr_chan = '0;
  logic wr_en = 1'b0, wr_cen = 1'b0;
  logic [MW-1:0] wr_mode = '0;
  logic preload_on = 1'b0, upd_sel = 1'b0, com_sw = 1'b0, trig_in = 1'b0;
  logic [NCH-1:0] act_en, act_cen;
  logic [NCH*MW-1:0] act_mode;
  logic com_pulse;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [W-1:0] m_pre [NCH];
  logic [W-1:0] m_act [NCH];
  logic m_trq = 1'b0;
  logic m_pulse = 1'b0;
  logic [31:0] rng = 32'h1d2c3b4a;

  always #2 clk = ~clk;

  comm_shadow_ctl #(.NUM_CH(NCH), .NUM_COMP(NCMP), .MODE_W(MW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_chan(wr_chan), .wr_en(wr_en), .wr_cen(wr_cen), .wr_mode(wr_mode),
    .preload_on(preload_on), .upd_sel(upd_sel), .com_sw(com_sw), .trig_in(trig_in),
    .act_en(act_en), .act_cen(act_cen), .act_mode(act_mode), .com_pulse(com_pulse)
  );

  function automatic logic [NCH*W-1:0] got_vec();
    logic [NCH*W-1:0] v;
    for (int c = 0; c < NCH; c++)
      v[c*W +: W] = {act_en[c], act_cen[c], act_mode[c*MW +: MW]};
    return v;
  endfunction

  function automatic logic [NCH*W-1:0] exp_vec();
    logic [NCH*W-1:0] v;
    for (int c = 0; c < NCH; c++) v[c*W +: W] = m_act[c];
    return v;
  endfunction

  task automatic check_all(input string tag);
    n_chk++;
    if (got_vec() !== exp_vec()) begin
      n_fail++;
      $display("FAIL %s active: got %h expected %h", tag, got_vec(), exp_vec());
    end
    n_chk++;
    if (com_pulse !== m_pulse || wr_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL %s pulse/ready: got %b%b expected %b1", tag, com_pulse, wr_ready, m_pulse);
    end
  endtask

  task automatic step(input logic wv, input logic [CW-1:0] ch, input logic [W-1:0] d,
                      input logic pl, input logic us, input logic sw, input logic tr,
                      input string tag);
    logic evt;
    logic [W-1:0] dm;
    wr_valid = wv; wr_chan = ch; {wr_en, wr_cen, wr_mode} = d;
    preload_on = pl; upd_sel = us; com_sw = sw; trig_in = tr;
    @(posedge clk);
    evt = sw | (us & tr & ~m_trq);
    for (int c = 0; c < NCH; c++) begin
      dm = (c < NCMP) ? d : {d[W-1], 1'b0, d[MW-1:0]};
      if (c < NCMP) begin
        if (pl && evt) m_act[c] = m_pre[c];
        else if (!pl && wv && int'(ch) == c) m_act[c] = dm;
      end else if (wv && int'(ch) == c) m_act[c] = dm;
      if (wv && int'(ch) == c) m_pre[c] = dm;
    end
    m_pulse = evt & pl;
    m_trq = tr;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin m_pre[c] = '0; m_act[c] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");
    // R2 direct write with preload off
    step(1, 0, 5'b10101, 0, 0, 0, 0, "R2");
    // R3 buffered write holds active copy
    step(1, 1, 5'b11011, 1, 0, 0, 0, "R3");
    step(1, 2, 5'b01110, 1, 0, 0, 0, "R3");
    step(1, 0, 5'b11111, 1, 0, 0, 0, "R3");
    // R4 trigger edge ignored when selection is software only
    step(0, 0, 0, 1, 0, 0, 1, "R4");
    step(0, 0, 0, 1, 0, 0, 0, "R4");
    // R4 software strobe transfers every channel, R9 pulse
    step(0, 0, 0, 1, 0, 1, 0, "R4 R9");
    step(0, 0, 0, 1, 0, 0, 0, "R9");
    // R5 trigger rising edge transfers, held level does not
    step(1, 2, 5'b10001, 1, 1, 0, 0, "R5");
    step(0, 0, 0, 1, 1, 0, 1, "R5");
    step(1, 2, 5'b00110, 1, 1, 0, 1, "R5");
    step(0, 0, 0, 1, 1, 0, 1, "R5");
    step(0, 0, 0, 1, 1, 0, 0, "R5");
    // R6 software strobe with trigger selection
    step(0, 0, 0, 1, 1, 1, 0, "R6");
    // R7 plain channels update at once, cen masked
    step(1, 4, 5'b11010, 1, 0, 0, 0, "R7");
    step(1, 5, 5'b01111, 0, 0, 0, 0, "R7");
    // R8 collision: old buffered word moves, new stays buffered
    step(1, 1, 5'b00011, 1, 0, 1, 0, "R8");
    step(0, 0, 0, 1, 0, 1, 0, "R8");
    // R11 out-of-range channels
    step(1, 6, 5'b11111, 0, 0, 0, 0, "R11");
    step(1, 7, 5'b11111, 1, 0, 1, 0, "R11");
    // R9 no pulse with preload off
    step(0, 0, 0, 0, 1, 1, 1, "R9");
    step(0, 0, 0, 0, 0, 0, 0, "R10");
    // sweep
    for (int i = 0; i < 4000; i++) begin
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      step(rng[14] | rng[15], rng[2:0], rng[7:3], rng[8] | rng[16], rng[9],
           rng[12:10] == 3'b000, rng[13], "R2 R3 R5 R6 R7 R8 R9 R11 sweep");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule